// File: doc/BRIEF.md
# Three-Operand Boolean Copy Engine

This block walks a run of 32-bit words through a single-port synchronous memory. For every word it fetches a source operand, a second operand and the present contents of the destination word. It merges the three bit by bit through an 8-bit function code that can describe any three-input boolean function, and it stores the merged word back at the destination. Once the word is written, the engine moves all three byte pointers forward by one word and lowers its word counter. It repeats this until the counter runs out.

Software fills the pointer, count and function registers with a load strobe and then pulses start. The engine raises busy while it works and pulses done once it finishes. After the run the pointer and count registers can be read on dedicated outputs. The function code follows the usual truth-table convention. Take the operand masks 0xF0 for the source, 0xCC for the second operand and 0xAA for the destination word. Evaluate the wanted expression bitwise on those masks, and the result is the code.

Top module: `tlblit_engine`

## Requirements
- R1: Result bit i equals bit {A[i],B[i],C[i]} of the function code, where A is the index MSB (bit 2) and C the LSB (bit 0). This makes 0xF0 select A, 0xCC select B and 0xAA select C, and any expression on those masks gives the matching function.
- R2: A is the word at the source pointer, B the word at the second-operand pointer, and C the word at the destination pointer before the write. The result is written to the destination pointer.
- R3: Code 0x00 writes all zeros, code 0xFF writes all ones and code 0xF0 writes A unchanged, whatever the operand values.
- R4: Each word costs exactly four memory requests: reads of A, B and C in that order, each waited out for the fixed read latency, then one write.
- R5: After each write, the source, destination and second-operand pointers each increase by 4. Read back after the run, each pointer equals its start value plus 4 times the count, and the count register reads 0.
- R6: Exactly the programmed number of words is processed. The word just past the destination region is left untouched.
- R7: A start with count 0 raises done in the next cycle and issues no memory request.
- R8: Busy is high from the cycle after an accepted start until the last write has been issued. Done is a one-cycle pulse in the cycle after the last write, and busy is low while done is high.
- R9: Start and register loads that arrive while busy is high are ignored. The run in progress finishes with its original pointers and count.
- R10: After reset, busy, done and mem_req are low and the pointer and count registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load the setup fields below (ignored while busy) |
| cfg_src | input | AW | Source byte pointer (A) |
| cfg_dst | input | AW | Destination byte pointer (C and result) |
| cfg_opb | input | AW | Second-operand byte pointer (B) |
| cfg_count | input | CW | Number of words to process |
| cfg_func | input | 8 | Three-input truth-table code |
| start | input | 1 | Begin a run (ignored while busy) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| src_ptr | output | AW | Current source pointer |
| dst_ptr | output | AW | Current destination pointer |
| opb_ptr | output | AW | Current second-operand pointer |
| words_left | output | CW | Remaining word count |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address of the request |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid RD_LAT cycles after a read request |

## Verification
The checks assume that software gives word-aligned pointers and that the memory returns read data exactly RD_LAT cycles after each read request. The bench's memory model keeps to that fixed latency, and every pointer it programs is a multiple of 4. The checks also assume that start and load may come at any time, so the bench drives both in the middle of a run to show they have no effect. The function-code checks take the code as fixed for the whole run, and the bench changes the code only between runs.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RREQ  = 3'd1,
    ST_RWAIT = 3'd2,
    ST_WRITE = 3'd3,
    ST_FIN   = 3'd4
  } tlb_state_e;

  typedef enum logic [1:0] {
    OP_A = 2'd0,
    OP_B = 2'd1,
    OP_C = 2'd2
  } tlb_opsel_e;
endpackage

// File: rtl/tlb_combine.sv
// Per-bit three-input lookup: each output bit indexes the 8-bit code.
module tlb_combine #(
  parameter int DW = 32
) (
  input  logic [7:0]    func,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic [DW-1:0] opc,
  output logic [DW-1:0] res
);
  for (genvar i = 0; i < DW; i++) begin : g_bit
    logic [2:0] idx;
    assign idx    = {opa[i], opb[i], opc[i]};
    assign res[i] = func[idx];
  end
endmodule

// File: rtl/tlb_ptr_bank.sv
// Pointer, count and code registers with load and per-word step.
module tlb_ptr_bank #(
  parameter int AW   = 32,
  parameter int CW   = 16,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [AW-1:0] opb_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [7:0]    func_i,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [AW-1:0] opb_q,
  output logic [CW-1:0] cnt_q,
  output logic [7:0]    func_q,
  output logic          cnt_zero,
  output logic          cnt_last
);
  localparam logic [AW-1:0] INC = AW'(STEP);
  localparam logic [CW-1:0] ONE = CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      dst_q  <= '0;
      opb_q  <= '0;
      cnt_q  <= '0;
      func_q <= '0;
    end else if (load) begin
      src_q  <= src_i;
      dst_q  <= dst_i;
      opb_q  <= opb_i;
      cnt_q  <= cnt_i;
      func_q <= func_i;
    end else if (step) begin
      src_q <= src_q + INC;
      dst_q <= dst_q + INC;
      opb_q <= opb_q + INC;
      cnt_q <= cnt_q - ONE;
    end
  end

  assign cnt_zero = (cnt_q == '0);
  assign cnt_last = (cnt_q == ONE);
endmodule

// File: rtl/tlb_seq.sv
// Word sequencer: read A, read B, read C (each with latency wait), write.
module tlb_seq
  import tlb_pkg::*;
#(
  parameter int RD_LAT = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       cnt_zero,
  input  logic       cnt_last,
  output tlb_state_e st_q,
  output tlb_opsel_e sel_q,
  output logic       cap_en,
  output logic       step_en,
  output logic       busy,
  output logic       done,
  output logic       idle
);
  localparam int LW = $clog2(RD_LAT + 1);
  localparam logic [LW-1:0] LAT = LW'(RD_LAT);
  localparam logic [LW-1:0] ONE = LW'(1);

  logic [LW-1:0] wcnt_q;
  logic          lat_hit;

  assign lat_hit = (wcnt_q == LAT);
  assign idle    = (st_q == ST_IDLE) || (st_q == ST_FIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      sel_q  <= OP_A;
      wcnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_FIN: begin
          sel_q <= OP_A;
          if (start) st_q <= cnt_zero ? ST_FIN : ST_RREQ;
          else       st_q <= ST_IDLE;
        end
        ST_RREQ: begin
          st_q   <= ST_RWAIT;
          wcnt_q <= ONE;
        end
        ST_RWAIT: begin
          if (lat_hit) begin
            if (sel_q == OP_C) begin
              st_q <= ST_WRITE;
            end else begin
              st_q  <= ST_RREQ;
              sel_q <= (sel_q == OP_A) ? OP_B : OP_C;
            end
          end else begin
            wcnt_q <= wcnt_q + ONE;
          end
        end
        ST_WRITE: begin
          sel_q <= OP_A;
          st_q  <= cnt_last ? ST_FIN : ST_RREQ;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cap_en  = (st_q == ST_RWAIT) && lat_hit;
  assign step_en = (st_q == ST_WRITE);
  assign busy    = !idle;
  assign done    = (st_q == ST_FIN);
endmodule

// File: rtl/tlb_opnd_regs.sv
// Holds the three fetched operand words.
module tlb_opnd_regs
  import tlb_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_en,
  input  tlb_opsel_e    sel,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] opa_q,
  output logic [DW-1:0] opb_q,
  output logic [DW-1:0] opc_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      opa_q <= '0;
      opb_q <= '0;
      opc_q <= '0;
    end else if (cap_en) begin
      unique case (sel)
        OP_A:    opa_q <= rdata;
        OP_B:    opb_q <= rdata;
        default: opc_q <= rdata;
      endcase
    end
  end
endmodule

// File: rtl/tlblit_engine.sv
// Three-pointer memory copy engine with a three-input truth-table combine.
module tlblit_engine
  import tlb_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int CW     = 16,
  parameter int RD_LAT = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_load,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [AW-1:0] cfg_opb,
  input  logic [CW-1:0] cfg_count,
  input  logic [7:0]    cfg_func,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] src_ptr,
  output logic [AW-1:0] dst_ptr,
  output logic [AW-1:0] opb_ptr,
  output logic [CW-1:0] words_left,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  localparam int STEP = DW / 8;

  tlb_state_e    st;
  tlb_opsel_e    sel;
  logic          cap_en, step_en, idle, cnt_zero, cnt_last;
  logic [7:0]    func_q;
  logic [DW-1:0] opa_q, opb_q, opc_q;

  tlb_ptr_bank #(.AW(AW), .CW(CW), .STEP(STEP)) u_ptrs (
    .clk(clk), .rst(rst),
    .load(cfg_load && idle), .step(step_en),
    .src_i(cfg_src), .dst_i(cfg_dst), .opb_i(cfg_opb),
    .cnt_i(cfg_count), .func_i(cfg_func),
    .src_q(src_ptr), .dst_q(dst_ptr), .opb_q(opb_ptr),
    .cnt_q(words_left), .func_q(func_q),
    .cnt_zero(cnt_zero), .cnt_last(cnt_last)
  );

  tlb_seq #(.RD_LAT(RD_LAT)) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .cnt_zero(cnt_zero), .cnt_last(cnt_last),
    .st_q(st), .sel_q(sel), .cap_en(cap_en), .step_en(step_en),
    .busy(busy), .done(done), .idle(idle)
  );

  tlb_opnd_regs #(.DW(DW)) u_opnd (
    .clk(clk), .rst(rst), .cap_en(cap_en), .sel(sel),
    .rdata(mem_rdata),
    .opa_q(opa_q), .opb_q(opb_q), .opc_q(opc_q)
  );

  tlb_combine #(.DW(DW)) u_comb (
    .func(func_q), .opa(opa_q), .opb(opb_q), .opc(opc_q),
    .res(mem_wdata)
  );

  assign mem_req = (st == ST_RREQ) || (st == ST_WRITE);
  assign mem_we  = (st == ST_WRITE);

  always_comb begin
    mem_addr = dst_ptr;
    if (st == ST_RREQ) begin
      unique case (sel)
        OP_A:    mem_addr = src_ptr;
        OP_B:    mem_addr = opb_ptr;
        default: mem_addr = dst_ptr;
      endcase
    end
  end
endmodule

// File: rtl/tlblit_engine_chk.sv
module tlblit_engine_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic [AW-1:0] src_ptr,
  input logic [AW-1:0] dst_ptr,
  input logic [AW-1:0] opb_ptr,
  input logic [7:0]    func_q
);
  localparam logic [AW-1:0] INC = AW'(DW / 8);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(busy && done)); // R8
  AST_WRITE_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (busy && mem_req)); // R4
  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (src_ptr == $past(src_ptr) + INC) && (dst_ptr == $past(dst_ptr) + INC)
               && (opb_ptr == $past(opb_ptr) + INC)); // R5
  AST_PTR_HOLD_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && !mem_we) |=> $stable(src_ptr) && $stable(dst_ptr) && $stable(opb_ptr)); // R9
  AST_CODE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (mem_we && func_q == 8'h00) |-> (mem_wdata == '0)); // R3
  AST_CODE_ONES: assert property (@(posedge clk) disable iff (rst)
    (mem_we && func_q == 8'hFF) |-> (mem_wdata == '1)); // R3
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[1:0] == 2'b00)); // R5
endmodule

bind tlblit_engine tlblit_engine_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .src_ptr(src_ptr), .dst_ptr(dst_ptr),
  .opb_ptr(opb_ptr), .func_q(func_q)
);

// File: tb/tlblit_engine_bench.sv
`timescale 1ns/1ps
module tlblit_engine_bench;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_load = 1'b0, start = 1'b0;
  logic [31:0] cfg_src = '0, cfg_dst = '0, cfg_opb = '0;
  logic [15:0] cfg_count = '0;
  logic [7:0]  cfg_func = '0;
  logic        busy, done, mem_req, mem_we;
  logic [31:0] src_ptr, dst_ptr, opb_ptr, mem_addr, mem_wdata, mem_rdata;
  logic [15:0] words_left;

  logic [31:0] mem [256];
  logic [31:0] rpipe [LAT];
  logic        tb_we = 1'b0;
  logic [7:0]  tb_idx = '0;
  logic [31:0] tb_data = '0;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  tlblit_engine #(.AW(32), .DW(32), .CW(16), .RD_LAT(LAT)) u_tlblit_engine (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_src(cfg_src),
    .cfg_dst(cfg_dst), .cfg_opb(cfg_opb), .cfg_count(cfg_count),
    .cfg_func(cfg_func), .start(start), .busy(busy), .done(done),
    .src_ptr(src_ptr), .dst_ptr(dst_ptr), .opb_ptr(opb_ptr),
    .words_left(words_left), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (tb_we) mem[tb_idx] <= tb_data;
    else if (mem_req && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    rpipe[0] <= mem[mem_addr[9:2]];
    for (int k = 1; k < LAT; k++) rpipe[k] <= rpipe[k-1];
  end
  assign mem_rdata = rpipe[LAT-1];

  // {func, A, B, C, expected}
  localparam logic [135:0] VEC [10] = '{
    {8'h00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'hFF, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF},
    {8'hF0, 32'h1234_5678, 32'hA5A5_A5A5, 32'h0F0F_0F0F, 32'h1234_5678},
    {8'hCC, 32'h1234_5678, 32'hA5A5_A5A5, 32'h0F0F_0F0F, 32'hA5A5_A5A5},
    {8'hAA, 32'h1234_5678, 32'hA5A5_A5A5, 32'h0F0F_0F0F, 32'h0F0F_0F0F},
    {8'h80, 32'hFF00_FF00, 32'hF0F0_F0F0, 32'hCCCC_CCCC, 32'hC000_C000},
    {8'h96, 32'hFF00_FF00, 32'hF0F0_F0F0, 32'hCCCC_CCCC, 32'hC33C_C33C},
    {8'hE8, 32'hFF00_FF00, 32'hF0F0_F0F0, 32'hCCCC_CCCC, 32'hFCC0_FCC0},
    {8'hCA, 32'hFF00_FF00, 32'hF0F0_F0F0, 32'hCCCC_CCCC, 32'hF0CC_F0CC},
    {8'h9F, 32'hFF00_FF00, 32'hF0F0_F0F0, 32'hCCCC_CCCC, 32'hC3FF_C3FF}
  };

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] addr, input logic [31:0] data);
    tb_we = 1'b1; tb_idx = addr[9:2]; tb_data = data;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic setup(input logic [31:0] s, d, o, input logic [15:0] n, input logic [7:0] f);
    cfg_src = s; cfg_dst = d; cfg_opb = o; cfg_count = n; cfg_func = f;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int reqs);
    int cyc = 0;
    reqs = 0;
    while (!done && cyc < 5000) begin
      if (mem_req) reqs++;
      cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int reqs;
    logic [31:0] ea, eb, ec;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(!busy && !done && !mem_req, "R10 ctl", {busy, done, mem_req}, 0);
    check(src_ptr == 0 && dst_ptr == 0 && opb_ptr == 0 && words_left == 0,
          "R10 regs", src_ptr | dst_ptr | opb_ptr, 0);

    // Vector table: single-word runs, R1 R2 R3
    for (int i = 0; i < 10; i++) begin
      poke(32'h040, VEC[i][127:96]);
      poke(32'h080, VEC[i][95:64]);
      poke(32'h0C0, VEC[i][63:32]);
      setup(32'h040, 32'h0C0, 32'h080, 16'd1, VEC[i][135:128]);
      wait_done(reqs);
      check(mem[8'h30] == VEC[i][31:0], $sformatf("R1 R2 R3 vec%0d", i), mem[8'h30], VEC[i][31:0]);
      check(reqs == 4, "R4 requests per word", reqs, 4);
    end

    // Multi-word XOR run with guard word: R5 R6 R8
    for (int k = 0; k < 4; k++) begin
      poke(32'h200 + 4*k, 32'h1111_0000 + k);
      poke(32'h300 + 4*k, 32'h0F0F_0000 * (k + 1));
      poke(32'h280 + 4*k, 32'h00FF_00FF << k);
    end
    poke(32'h290, 32'hDEAD_BEEF);
    setup(32'h200, 32'h280, 32'h300, 16'd4, 8'h96);
    check(busy, "R8 busy during run", busy, 1);
    wait_done(reqs);
    check(done && !busy, "R8 done with busy low", {done, busy}, 2);
    @(negedge clk);
    check(!done, "R8 done one cycle", done, 0);
    check(reqs == 16, "R4 R6 request total", reqs, 16);
    for (int k = 0; k < 4; k++) begin
      ea = 32'h1111_0000 + k; eb = 32'h0F0F_0000 * (k + 1); ec = 32'h00FF_00FF << k;
      check(mem[(32'h280 + 4*k) >> 2] == (ea ^ eb ^ ec), "R2 R6 xor word",
            mem[(32'h280 + 4*k) >> 2], ea ^ eb ^ ec);
    end
    check(mem[32'h290 >> 2] == 32'hDEAD_BEEF, "R6 guard word", mem[32'h290 >> 2], 32'hDEAD_BEEF);
    check(src_ptr == 32'h210 && dst_ptr == 32'h290 && opb_ptr == 32'h310,
          "R5 final pointers", src_ptr, 32'h210);
    check(words_left == 0, "R5 count readback", words_left, 0);

    // Zero count: R7
    setup(32'h000, 32'h004, 32'h008, 16'd0, 8'hFF);
    check(done, "R7 done next cycle", done, 1);
    check(!mem_req, "R7 no memory access", mem_req, 0);
    check(mem[1] != 32'hFFFF_FFFF || src_ptr == 0, "R7 pointers unchanged", src_ptr, 0);
    @(negedge clk);

    // Start and load while busy: R9
    for (int k = 0; k < 3; k++) begin
      poke(32'h100 + 4*k, 32'hCAFE_0000 + k);
      poke(32'h140 + 4*k, 32'h0);
    end
    poke(32'h14C, 32'h5555_AAAA);
    setup(32'h100, 32'h140, 32'h180, 16'd3, 8'hF0);
    repeat (5) @(negedge clk);
    cfg_src = 32'h020; cfg_dst = 32'h024; cfg_count = 16'd9; cfg_func = 8'h00;
    cfg_load = 1'b1; start = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0; start = 1'b0;
    wait_done(reqs);
    check(src_ptr == 32'h10C && dst_ptr == 32'h14C, "R9 pointers kept", src_ptr, 32'h10C);
    for (int k = 0; k < 3; k++)
      check(mem[(32'h140 + 4*k) >> 2] == 32'hCAFE_0000 + k, "R9 R3 copy kept",
            mem[(32'h140 + 4*k) >> 2], 32'hCAFE_0000 + k);
    check(mem[32'h14C >> 2] == 32'h5555_AAAA, "R9 no extra word", mem[32'h14C >> 2], 32'h5555_AAAA);
    repeat (3) @(negedge clk);
    check(!busy, "R9 no restart", busy, 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule